// File: doc/BRIEF.md
# Write Leveling Exit Sequencer

This block sits on the controller side of a DDR3-style memory interface. It takes one rank out of write leveling mode and returns it to normal operation. While leveling runs, the controller drives the data strobe and holds the termination pin high. When the leveling search issues its final strobe, it raises an exit request. The sequencer then carries out a fixed order of steps. It keeps the strobe driven for a margin window so that the last feedback bit can be captured. It then stops driving the strobe and lowers the termination pin in the same cycle. It waits until termination has really switched off. It then issues a single mode-register write to mode register 1, which clears the leveling enable bit. Finally it times the two recovery windows that follow that write.

All timing is counted in clock cycles and set by parameters. Two ready flags are produced. The first allows further mode-register writes. The second allows any command. A one-cycle done pulse closes the sequence. When a further rank still has to be leveled, the continue input is set. The sequencer then withholds the any-command flag, drives the strobe again and leaves the termination pin low.

Top module: `wlvl_exit_seq`

## Requirements
- R1: During and straight after synchronous reset: command NOP (code 2'b00), bank 0, address 0, strobe drive 1, termination pin 1, both ready flags 0, done 0, busy 0, latched result 0.
- R2: A request is accepted at the edge E0 on which it is sampled high while idle. The strobe drive stays 1 for cycles 0 to MARGIN_CYC-1 after E0 and is 0 from cycle MARGIN_CYC.
- R3: The latched result takes the feedback value present during cycle MARGIN_CYC-1, which is the last margin cycle. It keeps that value until the next sequence latches a new one.
- R4: The termination pin falls in the same cycle as the strobe drive, never earlier. It then stays low until reset.
- R5: The command bus carries only NOP, except for one single cycle at P = MARGIN_CYC + ODTL_OFF_CYC + AOF_CYC + IS_CYC after E0. In that cycle it carries MRS (code 2'b01) with bank 1.
- R6: The MRS address equals the mode-register-1 image captured at E0, with bit WL_BIT (default 7) cleared and every other bit unchanged.
- R7: The further-MRS flag is 0 from cycle 0 and becomes 1 at cycle P+MRD_CYC.
- R8: At cycle P+MOD_CYC, done is high for exactly one cycle. The any-command flag rises in that cycle and busy falls in that cycle. Busy is high from cycle 0 to cycle P+MOD_CYC-1.
- R9: A request that arrives while busy is ignored. A request still held high is next accepted at the edge that ends cycle P+MOD_CYC.
- R10: With the continue input sampled high at E0, the any-command flag stays 0 and the strobe drive returns to 1 at cycle P+MOD_CYC. The termination pin stays 0.
- R11: Both ready flags are 0 in cycle 0 of every accepted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exit_req | input | 1 | Request to leave leveling mode |
| next_rank | input | 1 | Continue with another rank after this exit |
| dq_fb | input | 1 | Leveling feedback bit from the data lane |
| mr1_image | input | 16 | Stored mode-register-1 value |
| cmd_o | output | 2 | Command code: NOP 2'b00, MRS 2'b01 |
| bank_o | output | 3 | Mode-register select for MRS |
| addr_o | output | 16 | Mode-register data for MRS |
| dqs_drive_o | output | 1 | Strobe output enable |
| odt_o | output | 1 | Termination pin |
| wl_result_o | output | 1 | Final leveling result |
| mrs_ok_o | output | 1 | Further mode-register writes allowed |
| cmd_ok_o | output | 1 | Any command allowed |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench drives a pseudo-random feedback bit on every cycle. A design that sampled the feedback one cycle early or late would latch a different value from the one the bench expects. It sends extra requests in the middle of a sequence, which shows up a sequencer that restarts or shortens its windows. It also holds the request high across the done cycle, to show whether a design accepts one cycle too soon. The mode-register images used have the leveling bit both set and clear, together with dense patterns. A mask placed on the wrong bit, or a mask that touches other bits, then shows up on the address. A continue-to-next-rank run checks that the any-command flag is held back and that the strobe drive returns while termination stays low.

// File: rtl/wlx_pkg.sv
package wlx_pkg;

    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned BANK_W    = 3;
    localparam logic [BANK_W-1:0] MR1_SEL = 3'd1;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_MRS = 2'b01
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_MARGIN,
        PH_TOFF,
        PH_WAIT
    } phase_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } cmd_word_t;

    localparam cmd_word_t IDLE_WORD = '{cmd: CMD_NOP, bank: '0, addr: '0};

    function automatic logic [ADDR_W-1:0] drop_bit(
        input logic [ADDR_W-1:0] v,
        input int unsigned       pos
    );
        logic [ADDR_W-1:0] r;
        r      = v;
        r[pos] = 1'b0;
        return r;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wlx_ctrl.sv
module wlx_ctrl
    import wlx_pkg::*;
#(
    parameter int unsigned MARGIN_CYC = 4,
    parameter int unsigned TOFF_CYC   = 6,
    parameter int unsigned CW         = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic exit_req,
    input  logic next_rank,
    input  logic dq_fb,
    input  logic finishing,
    output logic accept,
    output logic fire,
    output logic dqs_drive,
    output logic odt,
    output logic wl_result,
    output logic busy,
    output logic cont_q
);

    phase_e          phase;
    logic [CW-1:0]   cnt;
    logic            margin_last;

    assign accept      = (phase == PH_IDLE) && exit_req;
    assign margin_last = (phase == PH_MARGIN) && (cnt == CW'(MARGIN_CYC - 1));
    assign fire        = (phase == PH_TOFF) && (cnt == CW'(TOFF_CYC - 1));
    assign busy        = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            dqs_drive <= 1'b1;
            odt       <= 1'b1;
            wl_result <= 1'b0;
            cont_q    <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (exit_req) begin
                        phase  <= PH_MARGIN;
                        cnt    <= '0;
                        cont_q <= next_rank;
                    end
                end
                PH_MARGIN: begin
                    if (margin_last) begin
                        wl_result <= dq_fb;
                        dqs_drive <= 1'b0;
                        odt       <= 1'b0;
                        phase     <= PH_TOFF;
                        cnt       <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_TOFF: begin
                    if (fire) begin
                        phase <= PH_WAIT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (finishing) begin
                        phase <= PH_IDLE;
                        if (cont_q) begin
                            dqs_drive <= 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wlx_mrs_gen.sv
module wlx_mrs_gen
    import wlx_pkg::*;
#(
    parameter int unsigned WL_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] image,
    input  logic              fire,
    output cmd_word_t         word
);

    logic [ADDR_W-1:0] img_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            img_q <= '0;
            word  <= IDLE_WORD;
        end else begin
            if (capture) begin
                img_q <= image;
            end
            if (fire) begin
                word.cmd  <= CMD_MRS;
                word.bank <= MR1_SEL;
                word.addr <= drop_bit(img_q, WL_BIT);
            end else begin
                word <= IDLE_WORD;
            end
        end
    end

endmodule

// File: rtl/wlx_ready_track.sv
module wlx_ready_track #(
    parameter int unsigned MRD_CYC = 4,
    parameter int unsigned MOD_CYC = 12,
    parameter int unsigned CW      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fire,
    input  logic cont,
    output logic finishing,
    output logic mrs_ok,
    output logic cmd_ok,
    output logic done
);

    logic          active;
    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;

    assign nxt       = cnt + 1'b1;
    assign finishing = active && (nxt == CW'(MOD_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            mrs_ok <= 1'b0;
            cmd_ok <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clear) begin
                mrs_ok <= 1'b0;
                cmd_ok <= 1'b0;
            end
            if (fire) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (active) begin
                cnt <= nxt;
                if (nxt >= CW'(MRD_CYC)) begin
                    mrs_ok <= 1'b1;
                end
                if (finishing) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    cmd_ok <= ~cont;
                end
            end
        end
    end

endmodule

// File: rtl/wlvl_exit_seq.sv
module wlvl_exit_seq
    import wlx_pkg::*;
#(
    parameter int unsigned MARGIN_CYC   = 4,
    parameter int unsigned ODTL_OFF_CYC = 3,
    parameter int unsigned AOF_CYC      = 2,
    parameter int unsigned IS_CYC       = 1,
    parameter int unsigned MRD_CYC      = 4,
    parameter int unsigned MOD_CYC      = 12,
    parameter int unsigned WL_BIT       = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      exit_req,
    input  logic                      next_rank,
    input  logic                      dq_fb,
    input  logic [wlx_pkg::ADDR_W-1:0] mr1_image,
    output logic [1:0]                cmd_o,
    output logic [wlx_pkg::BANK_W-1:0] bank_o,
    output logic [wlx_pkg::ADDR_W-1:0] addr_o,
    output logic                      dqs_drive_o,
    output logic                      odt_o,
    output logic                      wl_result_o,
    output logic                      mrs_ok_o,
    output logic                      cmd_ok_o,
    output logic                      done_o,
    output logic                      busy_o
);

    localparam int unsigned TOFF_CYC = ODTL_OFF_CYC + AOF_CYC + IS_CYC;
    localparam int unsigned MAX_CNT  = max2(max2(MARGIN_CYC, TOFF_CYC), max2(MRD_CYC, MOD_CYC));
    localparam int unsigned CW       = bits_for(MAX_CNT);

    generate
        if (MARGIN_CYC < 1 || ODTL_OFF_CYC < 1 || AOF_CYC < 1 || IS_CYC < 1 ||
            MRD_CYC < 1 || MOD_CYC < MRD_CYC || WL_BIT >= ADDR_W) begin : g_bad_param
            initial $fatal(1, "wlvl_exit_seq: illegal timing or bit parameter");
        end
    endgenerate

    logic      accept;
    logic      fire;
    logic      finishing;
    logic      cont_q;
    cmd_word_t word;

    wlx_ctrl #(
        .MARGIN_CYC (MARGIN_CYC),
        .TOFF_CYC   (TOFF_CYC),
        .CW         (CW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .exit_req  (exit_req),
        .next_rank (next_rank),
        .dq_fb     (dq_fb),
        .finishing (finishing),
        .accept    (accept),
        .fire      (fire),
        .dqs_drive (dqs_drive_o),
        .odt       (odt_o),
        .wl_result (wl_result_o),
        .busy      (busy_o),
        .cont_q    (cont_q)
    );

    wlx_mrs_gen #(
        .WL_BIT (WL_BIT)
    ) u_mrs (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .image   (mr1_image),
        .fire    (fire),
        .word    (word)
    );

    wlx_ready_track #(
        .MRD_CYC (MRD_CYC),
        .MOD_CYC (MOD_CYC),
        .CW      (CW)
    ) u_rdy (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .fire      (fire),
        .cont      (cont_q),
        .finishing (finishing),
        .mrs_ok    (mrs_ok_o),
        .cmd_ok    (cmd_ok_o),
        .done      (done_o)
    );

    assign cmd_o  = word.cmd;
    assign bank_o = word.bank;
    assign addr_o = word.addr;

endmodule

// File: rtl/wlx_checker.sv
module wlx_checker #(
    parameter int unsigned WL_BIT = 7
) (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cmd_o,
    input logic [2:0]  bank_o,
    input logic [15:0] addr_o,
    input logic        dqs_drive_o,
    input logic        odt_o,
    input logic        mrs_ok_o,
    input logic        cmd_ok_o,
    input logic        done_o,
    input logic        busy_o
);

    assert_mrs_bank_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 2'b01) |-> (bank_o == 3'd1));

    assert_mrs_single_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 2'b01) |=> (cmd_o == 2'b00));

    assert_wl_bit_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 2'b01) |-> (addr_o[WL_BIT] == 1'b0));

    assert_odt_with_dqs_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(odt_o) |-> $fell(dqs_drive_o));

    assert_odt_stays_low_R4: assert property (@(posedge clk) disable iff (rst)
        !odt_o |=> !odt_o);

    assert_cmdok_after_mrsok_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_ok_o |-> mrs_ok_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_nop_while_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cmd_o == 2'b00));

endmodule

bind wlvl_exit_seq wlx_checker #(.WL_BIT(WL_BIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_o       (cmd_o),
    .bank_o      (bank_o),
    .addr_o      (addr_o),
    .dqs_drive_o (dqs_drive_o),
    .odt_o       (odt_o),
    .mrs_ok_o    (mrs_ok_o),
    .cmd_ok_o    (cmd_ok_o),
    .done_o      (done_o),
    .busy_o      (busy_o)
);

// File: tb/sim_wlvl_exit_seq.sv
module sim_wlvl_exit_seq;

    localparam int CLK_PERIOD = 10;
    localparam int M   = 4;
    localparam int ODL = 3;
    localparam int AOF = 2;
    localparam int TIS = 1;
    localparam int MRD = 4;
    localparam int MOD = 12;
    localparam int WLB = 7;
    localparam int P   = M + ODL + AOF + TIS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exit_req = 1'b0;
    logic        next_rank = 1'b0;
    logic        dq_fb = 1'b0;
    logic [15:0] mr1_image = '0;
    logic [1:0]  cmd_o;
    logic [2:0]  bank_o;
    logic [15:0] addr_o;
    logic        dqs_drive_o, odt_o, wl_result_o, mrs_ok_o, cmd_ok_o, done_o, busy_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit started  = 1'b0;

    wlvl_exit_seq #(
        .MARGIN_CYC(M), .ODTL_OFF_CYC(ODL), .AOF_CYC(AOF), .IS_CYC(TIS),
        .MRD_CYC(MRD), .MOD_CYC(MOD), .WL_BIT(WLB)
    ) u0 (
        .clk(clk), .rst(rst), .exit_req(exit_req), .next_rank(next_rank),
        .dq_fb(dq_fb), .mr1_image(mr1_image), .cmd_o(cmd_o), .bank_o(bank_o),
        .addr_o(addr_o), .dqs_drive_o(dqs_drive_o), .odt_o(odt_o),
        .wl_result_o(wl_result_o), .mrs_ok_o(mrs_ok_o), .cmd_ok_o(cmd_ok_o),
        .done_o(done_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: time since acceptance drives every expectation
    bit        m_busy;
    int        t;
    bit        m_cont;
    bit [15:0] m_img;
    bit [1:0]  e_cmd;
    bit [2:0]  e_bank;
    bit [15:0] e_addr;
    bit        e_dqs, e_odt, e_wl, e_mrs, e_cok, e_done;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_busy = 0; t = 0; m_cont = 0; m_img = 0;
            e_dqs = 1; e_odt = 1; e_wl = 0; e_mrs = 0; e_cok = 0; e_done = 0;
        end else begin
            e_done = 0;
            if (!m_busy) begin
                if (exit_req) begin
                    m_busy = 1; t = 0; m_cont = next_rank; m_img = mr1_image;
                    e_mrs = 0; e_cok = 0;
                end
            end else begin
                t = t + 1;
                if (t == M) begin
                    e_wl = dq_fb; e_dqs = 0; e_odt = 0;
                end
                if (t >= P + MRD) e_mrs = 1;
                if (t == P + MOD) begin
                    e_done = 1; e_cok = !m_cont;
                    if (m_cont) e_dqs = 1;
                    m_busy = 0;
                end
            end
        end
        if (!rst && m_busy && t == P) begin
            e_cmd = 2'b01; e_bank = 3'd1; e_addr = m_img & ~(16'h1 << WLB);
        end else begin
            e_cmd = 2'b00; e_bank = 3'd0; e_addr = 16'h0;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("R5", "cmd", 32'(cmd_o), 32'(e_cmd));
            chk("R5", "bank", 32'(bank_o), 32'(e_bank));
            chk("R6", "addr", 32'(addr_o), 32'(e_addr));
            chk("R2 R10", "dqs_drive", 32'(dqs_drive_o), 32'(e_dqs));
            chk("R4", "odt", 32'(odt_o), 32'(e_odt));
            chk("R3", "wl_result", 32'(wl_result_o), 32'(e_wl));
            chk("R7 R11", "mrs_ok", 32'(mrs_ok_o), 32'(e_mrs));
            chk("R8 R10 R11", "cmd_ok", 32'(cmd_ok_o), 32'(e_cok));
            chk("R8", "done", 32'(done_o), 32'(e_done));
            chk("R8 R9", "busy", 32'(busy_o), 32'(m_busy));
        end
    end

    // pseudo-random feedback bit, changed away from the active edge
    logic [7:0] lfsr = 8'hA5;
    always @(negedge clk) begin
        lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        dq_fb <= lfsr[0];
    end

    task automatic pulse_req(input bit cont, input logic [15:0] img);
        @(negedge clk);
        exit_req = 1'b1; next_rank = cont; mr1_image = img;
        @(negedge clk);
        exit_req = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done_o) break;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 explicit reset state
        chk("R1", "reset cmd", 32'(cmd_o), 32'h0);
        chk("R1", "reset dqs", 32'(dqs_drive_o), 32'h1);
        chk("R1", "reset odt", 32'(odt_o), 32'h1);
        chk("R1", "reset flags", {28'h0, mrs_ok_o, cmd_ok_o, done_o, busy_o}, 32'h0);

        // plain exit, dense image, with stray requests while busy (R9)
        pulse_req(1'b0, 16'hFFFF);
        repeat (2) @(negedge clk);
        exit_req = 1'b1; mr1_image = 16'h0000;
        @(negedge clk);
        exit_req = 1'b0;
        repeat (9) @(negedge clk);
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        wait_done();
        chk("R8", "cmd_ok at done", 32'(cmd_ok_o), 32'h1);
        repeat (3) @(negedge clk);

        // continue to next rank, leveling bit set in image
        pulse_req(1'b1, 16'h0086);
        wait_done();
        chk("R10", "cmd_ok held", 32'(cmd_ok_o), 32'h0);
        chk("R10", "dqs driven again", 32'(dqs_drive_o), 32'h1);
        chk("R10", "odt low", 32'(odt_o), 32'h0);
        repeat (2) @(negedge clk);

        // request held high across done: back-to-back sequences (R9)
        @(negedge clk);
        exit_req = 1'b1; next_rank = 1'b0; mr1_image = 16'h1234;
        repeat (P + 4) @(negedge clk);
        mr1_image = 16'h0080;
        wait_done();
        @(negedge clk);
        chk("R9", "re-accepted busy", 32'(busy_o), 32'h1);
        chk("R11", "flags cleared", {30'h0, mrs_ok_o, cmd_ok_o}, 32'h0);
        exit_req = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule